// File: doc/BRIEF.md
# Bit-Serial Bus-Loaded Adder

This block adds two unsigned words using a single one-bit full adder, a carry flip-flop and two rotating operand registers. Both operands reach the block over one shared input bus on consecutive cycles. A pulse on `start` opens the transaction. The block captures the first operand in the cycle after the pulse and the second operand in the cycle after that. It then forms the sum one bit per iteration, with a loop counter bounding the iterations.

In each iteration the sum bit replaces bit 0 of the first operand register and the carry flip-flop takes the new carry. Both registers then rotate right by one place. After `WIDTH` iterations the first operand register holds the sum in its natural bit order. A hardwired Moore controller drives the four datapath controls. The sum appears on `out_bus` while `done` is pulsed high for one cycle. The final carry is dropped, so the result is the sum modulo 2^WIDTH.

Top module: `bitserial_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle (state code 0). After that edge `done` is 0 and `out_bus` is 0.
- R2: A `start` sampled high in idle moves the block to the load-first state (code 1). In that state the next edge captures `in_bus` as the first operand, clears the carry and zeroes the loop counter.
- R3: The edge after the first capture takes `in_bus` as the second operand, from the load-second state (code 2).
- R4: Each iteration has two states. In the sum state (code 3), bit 0 of the first operand takes the full-adder sum of the two bit-0 values and the carry, and the carry takes the carry-out. In the rotate state (code 4), both operand registers rotate right by one bit and the loop counter increments.
- R5: Exactly `WIDTH` iterations run. The rotate state exits to the finish state (code 5) when the counter equals `WIDTH-1`. `done` is therefore high in the cycle that lies 2*WIDTH+3 cycles after the cycle in which `start` was sampled (19 cycles for `WIDTH`=8).
- R6: While `done` is high, `out_bus` equals (first operand + second operand) mod 2^WIDTH, and the carry-out is discarded.
- R7: `done` is high for exactly one cycle, and the block is idle in the following cycle, ready to accept a new `start` there.
- R8: A `start` outside idle has no effect: it changes neither the result, nor the latency, nor the number of `done` pulses. This includes a `start` in the finish cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Opens a transaction when sampled in idle |
| in_bus | input | WIDTH | Shared operand bus: first operand, then second operand |
| out_bus | output | WIDTH | Content of the first operand register; the sum while `done` is high |
| done | output | 1 | One-cycle pulse that marks a valid sum |

## Verification
The bench builds the block with the default `WIDTH` of 8, which gives a 3-bit loop counter and a fixed 19-cycle latency. That size makes every carry chain observable: 255+1 and 255+255 carry through all eight bit positions and wrap, and 0+0 and 128+128 exercise the top bit. Transactions are issued back to back, with `start` pulsed at random while the adder is busy. This puts the idle-only acceptance of `start` and the one-cycle `done` pulse under test.

// File: rtl/sadd_pkg.sv
// Package: shared controller state encoding and datapath control bundle
// for the bit-serial adder. Assumes state codes are fixed at 0..5.
package sadd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LDA   = 3'd1,
        ST_LDB   = 3'd2,
        ST_SUM   = 3'd3,
        ST_ROT   = 3'd4,
        ST_FIN   = 3'd5
    } sadd_state_t;

    typedef struct packed {
        logic ld_a;      // capture first operand, clear carry, zero counter
        logic ld_b;      // capture second operand
        logic sum_step;  // write sum bit into A[0], carry-out into carry
        logic rot_step;  // rotate both operands right, advance counter
        logic done;      // result valid
    } sadd_ctl_t;

endpackage

// File: rtl/sadd_counter.sv
// Module: modulo-2^CNT_W iteration counter with clear, increment and a
// last-iteration flag. Assumes WIDTH is a power of two of at least 2.
module sadd_counter #(
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic is_last
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: hold the iteration index, cleared on load, bumped per iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign is_last = (cnt_q == CNT_W'(WIDTH - 1));

    // R2: a clear leaves the counter at zero
    a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R4: an increment advances the counter by exactly one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/sadd_datapath.sv
// Module: operand registers, one-bit full adder and carry flip-flop.
// Assumes the controller asserts at most one of its controls per cycle.
module sadd_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_bus,
    input  sadd_pkg::sadd_ctl_t ctl,
    output logic [WIDTH-1:0] acc_out
);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] opb_q;
    logic             carry_q;
    logic             sum_bit;
    logic             carry_nxt;

    // Purpose: one-bit full adder on the two low bits and the carry.
    always_comb begin
        sum_bit   = acc_q[0] ^ opb_q[0] ^ carry_q;
        carry_nxt = (acc_q[0] & opb_q[0]) | (carry_q & (acc_q[0] ^ opb_q[0]));
    end

    // Purpose: first operand / accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ctl.ld_a) begin
            acc_q <= in_bus;
        end else if (ctl.sum_step) begin
            acc_q[0] <= sum_bit;
        end else if (ctl.rot_step) begin
            acc_q <= {acc_q[0], acc_q[WIDTH-1:1]};
        end
    end

    // Purpose: second operand register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opb_q <= '0;
        end else if (ctl.ld_b) begin
            opb_q <= in_bus;
        end else if (ctl.rot_step) begin
            opb_q <= {opb_q[0], opb_q[WIDTH-1:1]};
        end
    end

    // Purpose: carry flip-flop, cleared with the first load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (ctl.ld_a) begin
            carry_q <= 1'b0;
        end else if (ctl.sum_step) begin
            carry_q <= carry_nxt;
        end
    end

    assign acc_out = acc_q;

    // R2: first load captures the bus and clears the carry
    a_r2_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_a |=> (acc_q == $past(in_bus)) && !carry_q);

    // R3: second load captures the bus
    a_r3_load_second: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_b |=> (opb_q == $past(in_bus)));

    // R4: rotate step turns the second operand right by one
    a_r4_rotate_b: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rot_step |=> (opb_q == {$past(opb_q[0]), $past(opb_q[WIDTH-1:1])}));

    // R4: sum step leaves the upper accumulator bits untouched
    a_r4_sum_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sum_step |=> $stable(acc_q[WIDTH-1:1]));

endmodule

// File: rtl/sadd_ctrl.sv
// Module: hardwired Moore controller sequencing load, sum and rotate
// steps. Assumes the iteration counter flag reflects the current index.
module sadd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_last,
    output sadd_pkg::sadd_ctl_t ctl
);
    import sadd_pkg::*;

    sadd_state_t state_q;
    sadd_state_t state_nxt;

    // Purpose: next-state function.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nxt = ST_LDA;
            ST_LDA:  state_nxt = ST_LDB;
            ST_LDB:  state_nxt = ST_SUM;
            ST_SUM:  state_nxt = ST_ROT;
            ST_ROT:  state_nxt = is_last ? ST_FIN : ST_SUM;
            ST_FIN:  state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Purpose: Moore output decode, one control per state.
    always_comb begin
        ctl          = '0;
        ctl.ld_a     = (state_q == ST_LDA);
        ctl.ld_b     = (state_q == ST_LDB);
        ctl.sum_step = (state_q == ST_SUM);
        ctl.rot_step = (state_q == ST_ROT);
        ctl.done     = (state_q == ST_FIN);
    end

    // R7: done lasts one cycle and is followed by idle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.done |=> (!ctl.done && state_q == ST_IDLE));

    // R8: start outside idle never reopens the load sequence
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> (state_q != ST_LDA));

    // R5: last rotate leads to finish
    a_r5_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROT && is_last) |=> ctl.done);

    // R3: first load is always followed by second load
    a_r3_load_order: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_a |=> ctl.ld_b);

endmodule

// File: rtl/bitserial_adder.sv
// Module: top of the bit-serial adder. Operands arrive on one bus in the
// two cycles after start; the sum is valid while done is high.
// Assumes WIDTH is a power of two of at least 2.
module bitserial_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] in_bus,
    output logic [WIDTH-1:0] out_bus,
    output logic             done
);
    import sadd_pkg::*;

    sadd_ctl_t ctl;
    logic      is_last;

    sadd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_last (is_last),
        .ctl     (ctl)
    );

    sadd_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctl.ld_a),
        .inc     (ctl.rot_step),
        .is_last (is_last)
    );

    sadd_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bus  (in_bus),
        .ctl     (ctl),
        .acc_out (out_bus)
    );

    assign done = ctl.done;

    // R1: reset leaves done low and the output cleared
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!done && out_bus == '0));

endmodule

// File: tb/tb_bitserial_adder.sv
// Scoreboard bench: the driver task queues expected sums, the monitor
// pops them on each done pulse and compares value and latency.
module tb_bitserial_adder;
    localparam int W       = 8;
    localparam int LATENCY = 2 * W + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] in_bus = '0;
    logic [W-1:0] out_bus;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_done   = 0;
    int n_ops    = 0;
    logic [W-1:0] exp_q[$];
    int           cyc_q[$];
    logic         prev_done = 1'b0;
    logic         mon_en = 1'b0;

    bitserial_adder #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_bus(in_bus), .out_bus(out_bus), .done(done)
    );

    always #2 clk = ~clk;  // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare every done pulse against the scoreboard.
    always @(negedge clk) begin
        if (mon_en) begin
            if (done) begin
                n_done++;
                check(!prev_done, "R7 done longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    logic [W-1:0] e;
                    int           c;
                    e = exp_q.pop_front();
                    c = cyc_q.pop_front();
                    check(out_bus == e, "R6 sum on out_bus", out_bus, e);
                    check(cyc - c == LATENCY, "R5 latency", cyc - c, LATENCY);
                end
            end
            prev_done = done;
        end
    end

    // Driver: one transaction; noise pulses start and scrambles the bus while busy (R8).
    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit noise);
        @(negedge clk);
        start  = 1'b1;
        in_bus = W'($urandom);
        exp_q.push_back(a + b);
        cyc_q.push_back(cyc);
        n_ops++;
        @(negedge clk);
        start  = 1'b0;
        in_bus = a;       // R2 first operand
        @(negedge clk);
        in_bus = b;       // R3 second operand
        for (int i = 3; i < LATENCY; i++) begin
            @(negedge clk);
            in_bus = W'($urandom);
            start  = noise ? 1'($urandom) : 1'b0;
        end
        @(negedge clk);   // finish cycle
        in_bus = W'($urandom);
        start  = noise;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(out_bus == '0, "R1 out_bus after reset", out_bus, 0);
        mon_en = 1'b1;

        run_add(8'd0,   8'd0,   1'b0);   // R6 zero
        run_add(8'd255, 8'd1,   1'b0);   // R6 full carry chain, wrap
        run_add(8'd255, 8'd255, 1'b0);   // R6 carry-out discarded
        run_add(8'd128, 8'd128, 1'b0);   // R6 top bit carry
        run_add(8'd85,  8'd170, 1'b0);   // R4 alternating bits
        run_add(8'd6,   8'd4,   1'b1);   // R8 busy start ignored
        for (int k = 0; k < 12; k++) begin
            run_add(W'($urandom), W'($urandom), 1'($urandom));
        end
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(n_done == n_ops, "R8 done pulse count", n_done, n_ops);
        check(exp_q.size() == 0, "R5 pending results", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule